// File: doc/BRIEF.md
# Context-Switch Bus Cycle Sequencer

This block carries out the bus side of a workspace-pointer CPU's context-switch instruction: a branch that loads a new workspace pointer (WP) and program counter (PC) from a two-word vector. Only the direct-address operand form is handled. A start pulse hands the block the opcode address, the current WP and the status word (ST). The block then walks a fixed 17-step machine-cycle schedule on a word-wide memory bus:

- it fetches the opcode and the following word, which is taken as the vector address;
- it reads the new WP from the vector;
- it stores ST, the return PC and the old WP into registers 15, 14 and 13 of the new workspace;
- it reads the new PC from the second vector word.

Every step is reported as a read, a write or an internal cycle. The block keeps its own PC, WP and ST output registers and commits them only when the schedule ends. At that point it raises a one-clock done flag. A wait input lengthens bus steps only, so the step order does not change when memory is slow.

Top module: `ctxsw_seq`

## Requirements
- R1: While reset is held and after its release with no start, busy, done, mem_rd and mem_wr are 0, cycle_kind is 3 (idle), and pc_out, wp_out and st_out are 0.
- R2: A start seen while idle begins the schedule on the next clock. With mem_ready held high, busy stays high for exactly 17 clocks, and done is high on the clock after the last step.
- R3: cycle_kind encodes 0 = internal, 1 = read, 2 = write. Steps 1, 5, 7 and 16 are reads. Steps 10, 12 and 14 are writes. All other steps are internal, which gives exactly 7 bus accesses with no read-before-write on the register saves.
- R4: The reads go, in order, to the opcode address, the opcode address + 2, the vector address (the word read at step 5), and the vector address + 2.
- R5: The writes go, in order: ST to new WP + 30 (register 15), then opcode address + 4 to new WP + 28 (register 14), then the old WP to new WP + 26 (register 13). The new WP is the word read at step 7.
- R6: After the schedule, pc_out holds the word read at step 16, wp_out holds the word read at step 7, and st_out holds the ST given at start.
- R7: Bit 0 of every bus address is 0. Bit 0 is also cleared in the new WP and new PC, so odd input values or odd read data are aligned down to the word.
- R8: While mem_ready is low in a read or write step, the step does not advance, and mem_addr, mem_wdata, mem_rd and mem_wr hold their values. Internal steps ignore mem_ready and take one clock each.
- R9: A start pulse while busy has no effect on the running schedule, its addresses or its results.
- R10: pc_out, wp_out and st_out change only on the clock where done is high. They keep their previous values for the whole schedule.
- R11: done is high for exactly one clock per completed schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a context switch (ignored while busy) |
| pc_in | input | 16 | Opcode address (current PC) |
| wp_in | input | 16 | Current workspace pointer |
| st_in | input | 16 | Current status word |
| mem_addr | output | 16 | Byte address of the bus access, bit 0 always 0 |
| mem_wdata | output | 16 | Write data |
| mem_rd | output | 1 | Read strobe for the current step |
| mem_wr | output | 1 | Write strobe for the current step |
| mem_rdata | input | 16 | Read data, sampled when a read step completes |
| mem_ready | input | 1 | Bus step completes on a clock where this is high |
| cycle_kind | output | 2 | 0 internal, 1 read, 2 write, 3 idle |
| busy | output | 1 | Schedule in progress |
| done | output | 1 | One-clock flag after the last step |
| pc_out | output | 16 | Committed program counter |
| wp_out | output | 16 | Committed workspace pointer |
| st_out | output | 16 | Committed status word |

## Verification
The assertions assume that mem_rdata is valid on any clock where a read step sees mem_ready high. They also assume that mem_ready says nothing about internal steps. The bench drives read data from a combinational memory model that decodes mem_addr. It changes mem_ready only between clock edges, sometimes following a pseudo-random sequence that also drops it during internal steps. Start pulses are one clock wide and are driven between edges, including one issued in the middle of a schedule.

// File: rtl/ctxsw_pkg.sv
package ctxsw_pkg;

  localparam int unsigned SEQ_LEN = 17;
  localparam int unsigned STEP_W  = $clog2(SEQ_LEN + 1);

  typedef enum logic [1:0] {
    CYC_INT  = 2'd0,
    CYC_RD   = 2'd1,
    CYC_WR   = 2'd2,
    CYC_IDLE = 2'd3
  } cyc_kind_t;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_OPCODE,
    ACC_OPERAND,
    ACC_VEC_WP,
    ACC_SAVE_ST,
    ACC_SAVE_PC,
    ACC_SAVE_WP,
    ACC_VEC_PC
  } acc_t;

  // Which bus access, if any, a step of the schedule performs.
  function automatic acc_t step_access(input logic [STEP_W-1:0] s);
    acc_t a;
    case (s)
      STEP_W'(1):  a = ACC_OPCODE;
      STEP_W'(5):  a = ACC_OPERAND;
      STEP_W'(7):  a = ACC_VEC_WP;
      STEP_W'(10): a = ACC_SAVE_ST;
      STEP_W'(12): a = ACC_SAVE_PC;
      STEP_W'(14): a = ACC_SAVE_WP;
      STEP_W'(16): a = ACC_VEC_PC;
      default:     a = ACC_NONE;
    endcase
    return a;
  endfunction

  function automatic cyc_kind_t access_kind(input acc_t a);
    cyc_kind_t k;
    case (a)
      ACC_OPCODE, ACC_OPERAND, ACC_VEC_WP, ACC_VEC_PC: k = CYC_RD;
      ACC_SAVE_ST, ACC_SAVE_PC, ACC_SAVE_WP:           k = CYC_WR;
      default:                                         k = CYC_INT;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/ctxsw_step_ctrl.sv
module ctxsw_step_ctrl
  import ctxsw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mem_cycle,
  input  logic              ready,
  output logic [STEP_W-1:0] step,
  output logic              busy,
  output logic              advance,
  output logic              last_adv,
  output logic              done
);

  localparam logic [STEP_W-1:0] FIRST = STEP_W'(1);
  localparam logic [STEP_W-1:0] LAST  = STEP_W'(SEQ_LEN);

  logic [STEP_W-1:0] step_q, step_d;
  logic              done_q, done_d;

  assign busy     = (step_q != '0);
  assign advance  = busy && (!mem_cycle || ready);
  assign last_adv = advance && (step_q == LAST);

  always_comb begin
    step_d = step_q;
    done_d = 1'b0;
    if (!busy) begin
      if (start) step_d = FIRST;
    end else if (advance) begin
      if (step_q == LAST) begin
        step_d = '0;
        done_d = 1'b1;
      end else begin
        step_d = step_q + FIRST;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      done_q <= 1'b0;
    end else begin
      step_q <= step_d;
      done_q <= done_d;
    end
  end

  assign step = step_q;
  assign done = done_q;

  AST_INT_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !mem_cycle |=> step_q != $past(step_q)); // R8

  AST_WAIT_HOLDS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    busy && mem_cycle && !ready |=> step_q == $past(step_q)); // R8

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && (step_q > FIRST) |=> step_q != FIRST); // R9

  AST_DONE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R11

endmodule

// File: rtl/ctxsw_bus_unit.sv
module ctxsw_bus_unit
  import ctxsw_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic          advance,
  input  acc_t          acc,
  input  logic [AW-1:0] pc_in,
  input  logic [AW-1:0] wp_in,
  input  logic [AW-1:0] st_in,
  input  logic [AW-1:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] mem_wdata,
  output logic [AW-1:0] new_pc,
  output logic [AW-1:0] new_wp,
  output logic [AW-1:0] new_st
);

  localparam int            WORD_BYTES = AW / 8;
  localparam logic [AW-1:0] ALIGN      = ~AW'(1);
  localparam logic [AW-1:0] STEP_WORD  = AW'(WORD_BYTES);
  localparam logic [AW-1:0] RET_OFS    = AW'(2 * WORD_BYTES);
  localparam logic [AW-1:0] OFS_R13    = AW'(13 * WORD_BYTES);
  localparam logic [AW-1:0] OFS_R14    = AW'(14 * WORD_BYTES);
  localparam logic [AW-1:0] OFS_R15    = AW'(15 * WORD_BYTES);

  logic [AW-1:0] base_q, base_d;
  logic [AW-1:0] owp_q,  owp_d;
  logic [AW-1:0] st_q,   st_d;
  logic [AW-1:0] vec_q,  vec_d;
  logic [AW-1:0] nwp_q,  nwp_d;
  logic [AW-1:0] npc_q,  npc_d;

  logic          take_vec, take_nwp, take_npc;
  logic [AW-1:0] raw_addr;

  assign take_vec = advance && (acc == ACC_OPERAND);
  assign take_nwp = advance && (acc == ACC_VEC_WP);
  assign take_npc = advance && (acc == ACC_VEC_PC);

  always_comb begin
    base_d = base_q;
    owp_d  = owp_q;
    st_d   = st_q;
    vec_d  = vec_q;
    nwp_d  = nwp_q;
    npc_d  = npc_q;
    if (capture) begin
      base_d = pc_in & ALIGN;
      owp_d  = wp_in;
      st_d   = st_in;
    end
    if (take_vec) vec_d = mem_rdata;
    if (take_nwp) nwp_d = mem_rdata & ALIGN;
    if (take_npc) npc_d = mem_rdata & ALIGN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      owp_q  <= '0;
      st_q   <= '0;
      vec_q  <= '0;
      nwp_q  <= '0;
      npc_q  <= '0;
    end else begin
      base_q <= base_d;
      owp_q  <= owp_d;
      st_q   <= st_d;
      vec_q  <= vec_d;
      nwp_q  <= nwp_d;
      npc_q  <= npc_d;
    end
  end

  always_comb begin
    raw_addr  = '0;
    mem_wdata = '0;
    case (acc)
      ACC_OPCODE:  raw_addr = base_q;
      ACC_OPERAND: raw_addr = base_q + STEP_WORD;
      ACC_VEC_WP:  raw_addr = vec_q;
      ACC_VEC_PC:  raw_addr = (vec_q & ALIGN) + STEP_WORD;
      ACC_SAVE_ST: begin
        raw_addr  = nwp_q + OFS_R15;
        mem_wdata = st_q;
      end
      ACC_SAVE_PC: begin
        raw_addr  = nwp_q + OFS_R14;
        mem_wdata = base_q + RET_OFS;
      end
      ACC_SAVE_WP: begin
        raw_addr  = nwp_q + OFS_R13;
        mem_wdata = owp_q;
      end
      default: ;
    endcase
  end

  assign mem_addr = raw_addr & ALIGN;
  assign new_pc   = npc_q;
  assign new_wp   = nwp_q;
  assign new_st   = st_q;

endmodule

// File: rtl/ctxsw_arch_regs.sv
module ctxsw_arch_regs #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] new_pc,
  input  logic [AW-1:0] new_wp,
  input  logic [AW-1:0] new_st,
  output logic [AW-1:0] pc_q,
  output logic [AW-1:0] wp_q,
  output logic [AW-1:0] st_q
);

  logic [AW-1:0] pc_d, wp_d, st_d;

  always_comb begin
    pc_d = pc_q;
    wp_d = wp_q;
    st_d = st_q;
    if (load) begin
      pc_d = new_pc;
      wp_d = new_wp;
      st_d = new_st;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
      wp_q <= '0;
      st_q <= '0;
    end else begin
      pc_q <= pc_d;
      wp_q <= wp_d;
      st_q <= st_d;
    end
  end

endmodule

// File: rtl/ctxsw_seq.sv
module ctxsw_seq
  import ctxsw_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] pc_in,
  input  logic [AW-1:0] wp_in,
  input  logic [AW-1:0] st_in,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] mem_wdata,
  output logic          mem_rd,
  output logic          mem_wr,
  input  logic [AW-1:0] mem_rdata,
  input  logic          mem_ready,
  output logic [1:0]    cycle_kind,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] pc_out,
  output logic [AW-1:0] wp_out,
  output logic [AW-1:0] st_out
);

  logic [STEP_W-1:0] step;
  logic              advance, last_adv, mem_cycle, capture;
  acc_t              acc;
  cyc_kind_t         kind;
  logic [AW-1:0]     new_pc, new_wp, new_st;

  assign acc        = step_access(step);
  assign kind       = busy ? access_kind(acc) : CYC_IDLE;
  assign mem_cycle  = (kind == CYC_RD) || (kind == CYC_WR);
  assign mem_rd     = (kind == CYC_RD);
  assign mem_wr     = (kind == CYC_WR);
  assign cycle_kind = kind;
  assign capture    = !busy && start;

  ctxsw_step_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mem_cycle (mem_cycle),
    .ready     (mem_ready),
    .step      (step),
    .busy      (busy),
    .advance   (advance),
    .last_adv  (last_adv),
    .done      (done)
  );

  ctxsw_bus_unit #(.AW(AW)) u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (capture),
    .advance   (advance),
    .acc       (acc),
    .pc_in     (pc_in),
    .wp_in     (wp_in),
    .st_in     (st_in),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .new_pc    (new_pc),
    .new_wp    (new_wp),
    .new_st    (new_st)
  );

  ctxsw_arch_regs #(.AW(AW)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (last_adv),
    .new_pc (new_pc),
    .new_wp (new_wp),
    .new_st (new_st),
    .pc_q   (pc_out),
    .wp_q   (wp_out),
    .st_q   (st_out)
  );

  AST_BUS_HOLDS_ON_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) && !mem_ready |=>
      $stable(mem_addr) && $stable(mem_wdata) && $stable({mem_rd, mem_wr})); // R8

  AST_NO_READ_AFTER_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr && mem_ready |=> !mem_rd && !mem_wr); // R3

  AST_CTX_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({pc_out, wp_out, st_out}) |-> done); // R10

endmodule

// File: tb/ctxsw_seq_test.sv
module ctxsw_seq_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n, start, mem_ready;
  logic [15:0] pc_in, wp_in, st_in, mem_rdata;
  logic [15:0] mem_addr, mem_wdata, pc_out, wp_out, st_out;
  logic        mem_rd, mem_wr, busy, done;
  logic [1:0]  cycle_kind;

  int checks = 0;
  int errors = 0;

  logic [15:0] m_pc, m_opc, m_vec, m_nwp, m_npc;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctxsw_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .pc_in(pc_in), .wp_in(wp_in), .st_in(st_in),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .cycle_kind(cycle_kind), .busy(busy), .done(done),
    .pc_out(pc_out), .wp_out(wp_out), .st_out(st_out)
  );

  // Memory model: opcode, vector address, then the two vector words.
  always_comb begin
    if (mem_addr == (m_pc & 16'hFFFE))                 mem_rdata = m_opc;
    else if (mem_addr == (m_pc & 16'hFFFE) + 16'd2)    mem_rdata = m_vec;
    else if (mem_addr == (m_vec & 16'hFFFE))           mem_rdata = m_nwp;
    else if (mem_addr == (m_vec & 16'hFFFE) + 16'd2)   mem_rdata = m_npc;
    else                                               mem_rdata = 16'hBAD0;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_kind(input int n);
    if (n == 1 || n == 5 || n == 7 || n == 16) return 2'd1;
    if (n == 10 || n == 12 || n == 14)         return 2'd2;
    return 2'd0;
  endfunction

  task automatic run_seq(input string name, input logic [15:0] pc, wp, st,
                         vec, nwp, npc, input bit stall, input bit poke);
    logic [15:0] e_addr [7];
    logic [15:0] e_data [7];
    logic [1:0]  e_kind [7];
    logic [15:0] pc_prev, wp_prev, st_prev, held_addr, held_data, lfsr;
    int steps, accs, clocks, stalls, guard;
    bit was_wait;
    steps = 0; accs = 0; clocks = 0; stalls = 0; guard = 0;
    was_wait = 1'b0; lfsr = 16'hACE1;
    held_addr = '0; held_data = '0;
    e_addr[0] = pc & 16'hFFFE;                       e_kind[0] = 2'd1; e_data[0] = '0;
    e_addr[1] = (pc & 16'hFFFE) + 16'd2;             e_kind[1] = 2'd1; e_data[1] = '0;
    e_addr[2] = vec & 16'hFFFE;                      e_kind[2] = 2'd1; e_data[2] = '0;
    e_addr[3] = (nwp & 16'hFFFE) + 16'd30;           e_kind[3] = 2'd2; e_data[3] = st;
    e_addr[4] = (nwp & 16'hFFFE) + 16'd28;           e_kind[4] = 2'd2; e_data[4] = (pc & 16'hFFFE) + 16'd4;
    e_addr[5] = (nwp & 16'hFFFE) + 16'd26;           e_kind[5] = 2'd2; e_data[5] = wp;
    e_addr[6] = (vec & 16'hFFFE) + 16'd2;            e_kind[6] = 2'd1; e_data[6] = '0;
    pc_prev = pc_out; wp_prev = wp_out; st_prev = st_out;

    @(negedge clk);
    m_pc = pc; m_opc = 16'h0420; m_vec = vec; m_nwp = nwp; m_npc = npc;
    pc_in = pc; wp_in = wp; st_in = st; mem_ready = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy && guard < 1000) begin
      guard++;
      clocks++;
      if (stall) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        mem_ready = lfsr[0] | lfsr[4];
      end else begin
        mem_ready = 1'b1;
      end
      if (poke && steps == 5) begin
        start = 1'b1; pc_in = 16'h7770; wp_in = 16'h1110; st_in = 16'hFFFF;
      end else begin
        start = 1'b0;
      end
      if (steps == 8)
        chk(pc_out == pc_prev && wp_out == wp_prev && st_out == st_prev, "R10",
            {name, " outputs held mid-run"}, {pc_out, wp_out}, {pc_prev, wp_prev});
      chk(cycle_kind == exp_kind(steps + 1), "R3", {name, " step kind"},
          {16'(steps + 1), 14'd0, cycle_kind}, {16'(steps + 1), 14'd0, exp_kind(steps + 1)});
      if (mem_rd || mem_wr) begin
        if (was_wait)
          chk(mem_addr == held_addr && mem_wdata == held_data, "R8",
              {name, " bus held in wait"}, {mem_addr, mem_wdata}, {held_addr, held_data});
        if (mem_ready) begin
          if (accs < 7) begin
            chk(mem_addr[0] == 1'b0, "R7", {name, " address aligned"}, mem_addr, e_addr[accs]);
            chk(cycle_kind == e_kind[accs] && mem_addr == e_addr[accs],
                (e_kind[accs] == 2'd1) ? "R4" : "R5", {name, " access address"},
                {14'd0, cycle_kind, mem_addr}, {14'd0, e_kind[accs], e_addr[accs]});
            if (e_kind[accs] == 2'd2)
              chk(mem_wdata == e_data[accs], "R5", {name, " write data"}, mem_wdata, e_data[accs]);
          end
          accs++;
          steps++;
          was_wait = 1'b0;
        end else begin
          stalls++;
          was_wait = 1'b1;
          held_addr = mem_addr; held_data = mem_wdata;
        end
      end else begin
        steps++;
        was_wait = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0; mem_ready = 1'b1;
    chk(accs == 7, "R3", {name, " access count"}, accs, 7);
    chk(steps == 17, "R2", {name, " step count"}, steps, 17);
    chk(clocks == 17 + stalls, "R8", {name, " busy clocks"}, clocks, 17 + stalls);
    chk(done == 1'b1, "R2", {name, " done after last step"}, done, 1);
    chk(pc_out == (npc & 16'hFFFE), "R6", {name, " new PC"}, pc_out, npc & 16'hFFFE);
    chk(wp_out == (nwp & 16'hFFFE), "R6", {name, " new WP"}, wp_out, nwp & 16'hFFFE);
    chk(st_out == st, "R6", {name, " ST kept"}, st_out, st);
    pc_prev = pc_out; wp_prev = wp_out;
    @(negedge clk);
    chk(done == 1'b0, "R11", {name, " done one clock"}, done, 0);
    chk(pc_out == pc_prev && wp_out == wp_prev, "R10", {name, " outputs stable after"},
        {pc_out, wp_out}, {pc_prev, wp_prev});
  endtask

  task automatic test_reset;
    rst_n = 1'b0; start = 1'b0; mem_ready = 1'b1;
    pc_in = '0; wp_in = '0; st_in = '0;
    m_pc = 16'h0100; m_opc = '0; m_vec = 16'h0200; m_nwp = '0; m_npc = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_rd && !mem_wr && cycle_kind == 2'd3, "R1",
        "in reset", {busy, done, mem_rd, mem_wr, cycle_kind}, 6'b000011);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !done && cycle_kind == 2'd3, "R1", "after release",
        {busy, done, cycle_kind}, 4'b0011);
    chk(pc_out == 0 && wp_out == 0 && st_out == 0, "R1", "context cleared",
        {pc_out, wp_out}, 32'd0);
  endtask

  task automatic test_idle_start_timing;
    // R2: busy rises on the clock after start.
    @(negedge clk);
    chk(!busy, "R2", "idle before start", busy, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    test_reset();
    test_idle_start_timing();
    run_seq("basic",   16'h6000, 16'h83E0, 16'h2003, 16'hA000, 16'h8300, 16'h6100, 1'b0, 1'b0);
    run_seq("second",  16'h1234, 16'h2000, 16'hC00F, 16'h3000, 16'h4000, 16'h5006, 1'b0, 1'b0);
    run_seq("odd",     16'h1001, 16'h2222, 16'h0001, 16'hA001, 16'h8301, 16'h6001, 1'b0, 1'b0);
    run_seq("waits",   16'h4800, 16'h8300, 16'h1234, 16'hB000, 16'h7F00, 16'h4A02, 1'b1, 1'b0);
    run_seq("restart", 16'h0C00, 16'h5000, 16'h0F0F, 16'h0E00, 16'h6000, 16'h0D00, 1'b0, 1'b1);
    run_seq("mixed",   16'hFFF0, 16'h0010, 16'h8000, 16'h0040, 16'h0080, 16'h00A0, 1'b1, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule